// File: doc/BRIEF.md
# Reduced-Height Radix-4 Booth Multiplier

This block multiplies two signed two's complement operands of N bits (8 by default) and returns the full 2N-bit signed product. It recodes the multiplier into N/2 radix-4 Booth digits in the set {-2, -1, 0, +1, +2}. Each digit selects zero, the multiplicand, or twice the multiplicand, with or without a sign change. That selection forms one partial-product row.

A common Booth array has one column of height N/2+1. This happens because every row's "+1" for negation is added at that row's least significant bit. Here the top row is built directly as the two's complement of its selected multiple. Its increment is computed by a parallel prefix-OR network that runs alongside the other row selectors. The lower rows' increments fit into gaps below the rows above them. As a result, no column holds more than N/2 bits.

Sign extension uses an inverted-sign prefix on each row plus a folded constant, so the rows need no long runs of copied sign bits. A chain of carry-save layers reduces the rows to two vectors, and a carry-propagate adder produces the product. An optional output register, with a synchronous active-high reset, gives the result a fixed one-cycle latency.

Top module: `booth_r4_mult`

## Requirements
- R1: With the default output register, `product` equals the exact signed product of `mcand` and `mplier` as a 2N-bit two's complement value, one rising clock edge after the operands are captured, for every operand pair.
- R2: A zero multiplier gives a zero product for every multiplicand.
- R3: A zero multiplicand gives a zero product for every multiplier, even when rows are negated. Each negated all-zero row must cancel exactly with its correction bit.
- R4: The most negative operand times itself (-128 × -128 for N=8) gives +2^(2N-2), which is 16384 for N=8.
- R5: The top Booth digit is formed from `mplier` bits [N-1:N-3]. When these bits are 100, 101 or 110 (digit -2, -1, -1), the top row is negated inside itself, and the product is still exact.
- R6: When the multiplicand is the most negative value, the doubled and negated multiples exceed N+1 bits, and the product is still exact for every multiplier.
- R7: While `rst` is high at a rising edge, `product` reads zero after that edge, whatever the operands are.
- R8: For nonzero operands, bit 2N-1 of `product` equals the XOR of the operand sign bits (bit N-1 of each).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset that clears the output register |
| mcand | input | N | Signed multiplicand |
| mplier | input | N | Signed multiplier, recoded into Booth digits |
| product | output | 2N | Signed product |

## Verification
The default configuration registers the result, so every product is due exactly one rising edge after its operands are presented. A zeroed output is likewise due one edge after a reset edge.

The bench changes operands on the falling edge and stores the expected value in a queue. It compares that value on the next falling edge, after the capturing edge has settled. All 65,536 operand pairs are swept this way, one pair per cycle.

Each compare is labelled with the requirement its operands stress: zero operands, the most negative square, a most negative multiplicand, or a negative top digit.

// File: rtl/booth_mult_pkg.sv
package booth_mult_pkg;

    // Default operand width; must be even and at least 4.
    localparam int unsigned BM_WIDTH = 8;

    // Control for one partial-product row.
    typedef struct packed {
        logic neg;   // change the sign of the selection
        logic two;   // select twice the multiplicand
        logic one;   // select the multiplicand
    } booth_ctl_t;

    // Variant choice for the final two-vector adder.
    typedef enum logic {
        CPA_NATIVE = 1'b0,
        CPA_RIPPLE = 1'b1
    } cpa_kind_e;

    // Recode one overlapping triple {b(2i+1), b(2i), b(2i-1)}.
    // Digit value is -2*t[2] + t[1] + t[0]; 000 and 111 give no selection
    // and no negation.
    function automatic booth_ctl_t booth_recode(input logic [2:0] trip);
        booth_ctl_t c;
        c.one = trip[1] ^ trip[0];
        c.two = (trip[2] & ~trip[1] & ~trip[0]) | (~trip[2] & trip[1] & trip[0]);
        c.neg = trip[2] & ~(trip[1] & trip[0]);
        return c;
    endfunction

    // Column position of the least significant bit of row r.
    function automatic int unsigned row_offset(input int unsigned r);
        return 2 * r;
    endfunction

endpackage

// File: rtl/booth_digit_enc.sv
module booth_digit_enc
    import booth_mult_pkg::*;
#(
    parameter int unsigned N = BM_WIDTH
) (
    input  logic [N-1:0]              mplier,
    output booth_ctl_t [N/2-1:0]      ctl
);
    localparam int unsigned D = N / 2;

    // Implicit zero below the least significant multiplier bit.
    logic [N:0] ext;
    assign ext = {mplier, 1'b0};

    for (genvar i = 0; i < D; i++) begin : g_digit
        assign ctl[i] = booth_recode(ext[2*i+2 : 2*i]);
    end

endmodule

// File: rtl/booth_pp_row.sv
module booth_pp_row
    import booth_mult_pkg::*;
#(
    parameter int unsigned N   = BM_WIDTH,
    parameter int unsigned ROW = 0
) (
    input  logic [N-1:0]   mcand,
    input  booth_ctl_t     ctl,
    output logic [2*N-1:0] row
);
    localparam int unsigned D   = N / 2;
    localparam int unsigned OFS = row_offset(ROW);

    if (ROW == D - 1) begin : g_last
        // Top row: full two's complement in place, no separate +1 bit.
        logic [N+1:0] mult;
        logic [N+1:0] below;
        logic [N+1:0] twos;

        always_comb begin
            mult = '0;
            if (ctl.one)
                mult = {{2{mcand[N-1]}}, mcand};
            else if (ctl.two)
                mult = {mcand[N-1], mcand, 1'b0};
        end

        // Negation flips every bit above the lowest set bit. Each flip
        // enable is an independent OR of the bits below it, so all of them
        // settle in parallel with the other rows' selectors.
        assign below[0] = 1'b0;
        for (genvar k = 1; k < N + 2; k++) begin : g_pre
            assign below[k] = |mult[k-1:0];
        end

        assign twos = mult ^ ({(N+2){ctl.neg}} & below);

        // Top two bits carry the folded constant 2'b11.
        always_comb begin
            row = '0;
            row[OFS +: N]     = twos[N-1:0];
            row[OFS + N +: 2] = twos[N+1:N] + 2'b11;
        end
    end else if (ROW == 0) begin : g_first
        logic [N:0] mult;
        logic [N:0] inv;

        assign mult = ctl.one ? {mcand[N-1], mcand} :
                      ctl.two ? {mcand, 1'b0}       : '0;
        assign inv  = mult ^ {(N+1){ctl.neg}};

        // Prefix ~s s s replaces the sign run and part of the constant.
        always_comb begin
            row = '0;
            row[N-1:0] = inv[N-1:0];
            row[N+2:N] = {~inv[N], inv[N], inv[N]};
        end
    end else begin : g_mid
        logic [N:0] mult;
        logic [N:0] inv;

        assign mult = ctl.one ? {mcand[N-1], mcand} :
                      ctl.two ? {mcand, 1'b0}       : '0;
        assign inv  = mult ^ {(N+1){ctl.neg}};

        // Prefix 1 ~s.
        always_comb begin
            row = '0;
            row[OFS +: N]   = inv[N-1:0];
            row[OFS + N]    = ~inv[N];
            row[OFS + N + 1] = 1'b1;
        end
    end

endmodule

// File: rtl/csa_row.sv
module csa_row #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] sum,
    output logic [W-1:0] carry   // already weighted one column up
);
    assign carry[0] = 1'b0;

    for (genvar k = 0; k < W; k++) begin : g_bit
        assign sum[k] = x[k] ^ y[k] ^ z[k];
        if (k < W - 1) begin : g_maj
            assign carry[k+1] = (x[k] & y[k]) | (x[k] & z[k]) | (y[k] & z[k]);
        end
    end

endmodule

// File: rtl/cpa_row.sv
module cpa_row
    import booth_mult_pkg::*;
#(
    parameter int unsigned W    = 16,
    parameter cpa_kind_e   KIND = CPA_RIPPLE
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum
);
    if (KIND == CPA_NATIVE) begin : g_native
        assign sum = x + y;
    end else begin : g_ripple
        always_comb begin
            logic c;
            c = 1'b0;
            for (int k = 0; k < W; k++) begin
                sum[k] = x[k] ^ y[k] ^ c;
                c      = (x[k] & y[k]) | (c & (x[k] ^ y[k]));
            end
        end
    end

endmodule

// File: rtl/booth_r4_mult.sv
module booth_r4_mult
    import booth_mult_pkg::*;
#(
    parameter int unsigned N        = BM_WIDTH,
    parameter bit          REG_OUT  = 1'b1,
    parameter cpa_kind_e   CPA_KIND = CPA_RIPPLE
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic [2*N-1:0] product
);
    localparam int unsigned D  = N / 2;
    localparam int unsigned PW = 2 * N;

    booth_ctl_t [D-1:0] ctl;
    logic [PW-1:0] body [D];
    logic [PW-1:0] rows [D];

    booth_digit_enc #(.N(N)) u_enc (
        .mplier (mplier),
        .ctl    (ctl)
    );

    for (genvar i = 0; i < D; i++) begin : g_row
        booth_pp_row #(.N(N), .ROW(i)) u_row (
            .mcand (mcand),
            .ctl   (ctl[i]),
            .row   (body[i])
        );
        // The +1 of row i-1 sits in the empty columns under row i.
        if (i == 0) begin : g_base
            assign rows[i] = body[i];
        end else begin : g_fill
            assign rows[i] = body[i] | (PW'(ctl[i-1].neg) << row_offset(i-1));
        end
    end

    // Carry-save chain: N/2 rows down to two vectors.
    logic [PW-1:0] sum_v [1:D-1];
    logic [PW-1:0] car_v [1:D-1];

    assign sum_v[1] = rows[0];
    assign car_v[1] = rows[1];

    for (genvar j = 2; j < D; j++) begin : g_csa
        csa_row #(.W(PW)) u_csa (
            .x     (sum_v[j-1]),
            .y     (car_v[j-1]),
            .z     (rows[j]),
            .sum   (sum_v[j]),
            .carry (car_v[j])
        );
    end

    logic [PW-1:0] total;

    cpa_row #(.W(PW), .KIND(CPA_KIND)) u_cpa (
        .x   (sum_v[D-1]),
        .y   (car_v[D-1]),
        .sum (total)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                product <= '0;
            else
                product <= total;
        end
    end else begin : g_comb
        assign product = total;
    end

endmodule

// File: rtl/booth_r4_mult_chk.sv
module booth_r4_mult_chk #(
    parameter int unsigned N   = 8,
    parameter bit          LAT = 1'b1
) (
    input logic           clk,
    input logic           rst,
    input logic [N-1:0]   mcand,
    input logic [N-1:0]   mplier,
    input logic [2*N-1:0] product
);
    localparam logic [N-1:0]   MINV = N'(1) << (N - 1);
    localparam logic [2*N-1:0] SQ   = (2*N)'(1) << (2*N - 2);

    logic signed [2*N-1:0] exp_w;
    assign exp_w = $signed(mcand) * $signed(mplier);

    if (LAT) begin : g_seq
        // R1
        prod_match_chk: assert property (@(posedge clk) disable iff (rst)
            !rst |=> product == $past(exp_w));

        // R2
        zero_mplier_chk: assert property (@(posedge clk) disable iff (rst)
            mplier == '0 |=> product == '0);

        // R3
        zero_mcand_chk: assert property (@(posedge clk) disable iff (rst)
            mcand == '0 |=> product == '0);

        // R4
        min_square_chk: assert property (@(posedge clk) disable iff (rst)
            (mcand == MINV && mplier == MINV) |=> product == SQ);

        // R7
        reset_clear_chk: assert property (@(posedge clk)
            rst |=> product == '0);

        // R8
        sign_rule_chk: assert property (@(posedge clk) disable iff (rst)
            (mcand != '0 && mplier != '0) |=>
                product[2*N-1] == ($past(mcand[N-1]) ^ $past(mplier[N-1])));
    end else begin : g_now
        // R1
        prod_now_chk: assert property (@(posedge clk) disable iff (rst)
            product == exp_w);

        // R2
        zero_mplier_now_chk: assert property (@(posedge clk) disable iff (rst)
            mplier == '0 |-> product == '0);

        // R3
        zero_mcand_now_chk: assert property (@(posedge clk) disable iff (rst)
            mcand == '0 |-> product == '0);

        // R4
        min_square_now_chk: assert property (@(posedge clk) disable iff (rst)
            (mcand == MINV && mplier == MINV) |-> product == SQ);
    end

endmodule

bind booth_r4_mult booth_r4_mult_chk #(.N(N), .LAT(REG_OUT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mcand   (mcand),
    .mplier  (mplier),
    .product (product)
);

// File: tb/booth_r4_mult_test.sv
`timescale 1ns/1ps
module booth_r4_mult_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mcand = 8'd5;
    logic [7:0]  mplier = 8'd7;
    logic [15:0] product;

    int checks = 0;
    int fails  = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    int          sgn_q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    booth_r4_mult uut (
        .clk     (clk),
        .rst     (rst),
        .mcand   (mcand),
        .mplier  (mplier),
        .product (product)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: product actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Requirement stressed by an operand pair.
    function automatic string tag_of(input int i, input int j);
        logic [7:0] bj;
        bj = 8'(j);
        if (i == -128 && j == -128) return "R4";
        if (j == 0)                 return "R2";
        if (i == 0)                 return "R3";
        if (i == -128)              return "R6";
        if (bj[7:5] inside {3'b100, 3'b101, 3'b110}) return "R5";
        return "R1";
    endfunction

    task automatic push(input int i, input int j);
        exp_q.push_back(16'(i * j));
        tag_q.push_back(tag_of(i, j));
        if (i != 0 && j != 0)
            sgn_q.push_back(((i < 0) != (j < 0)) ? 1 : 0);
        else
            sgn_q.push_back(-1);
    endtask

    task automatic pop_check();
        if (exp_q.size() > 0) begin
            logic [15:0] e;
            string       t;
            int          s;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            s = sgn_q.pop_front();
            check(t, product, e);
            if (s >= 0)
                check("R8", {15'd0, product[15]}, 16'(s));
        end
    endtask

    initial begin
        // R7: reset holds output at zero with nonzero operands applied
        @(negedge clk);
        @(negedge clk);
        check("R7", product, 16'h0000);
        rst = 1'b0;

        // Exhaustive sweep, one pair per cycle, one-cycle latency
        for (int i = -128; i < 128; i++) begin
            for (int j = -128; j < 128; j++) begin
                @(negedge clk);
                pop_check();
                mcand  = 8'(i);
                mplier = 8'(j);
                push(i, j);
            end
        end
        @(negedge clk);
        pop_check();

        // R7: reset in mid-run clears a nonzero result
        mcand  = 8'hFF;
        mplier = 8'hFF;
        rst    = 1'b1;
        @(negedge clk);
        check("R7", product, 16'h0000);
        rst    = 1'b0;
        mcand  = 8'd3;
        mplier = 8'd3;
        push(3, 3);
        @(negedge clk);
        pop_check();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule